// File: doc/BRIEF.md
# Parallel Sampling Converter Interface Emulator

This block stands in for the digital side of a 12-bit parallel sampling converter so that a host controller can be exercised without the real part. The host drives a read/convert select line and an active-low chip select. The block answers with an idle indicator that drops for the length of a conversion. Its data bus is modelled as a 12-bit value plus an output enable, with a zero value standing for high impedance.

A conversion starts when the read/convert line falls while chip select is low. At that edge the block takes the value on a test sample port, which acts as the sample-and-hold, so later changes on that port have no effect on the result. After a short lead delay the idle indicator goes low for a fixed number of cycles. The result register is loaded a few cycles before the indicator returns high, so the data is already settled when idle rises. The bus turns on only when read/convert is high, chip select is low and the block is idle. It does so after an access delay, and it lets go after a relinquish delay. A convert request made while a conversion is running is dropped and raises a sticky protocol-violation flag.

Top module: `adc_iface_emu`

## Requirements
- R1: A conversion starts only on a clock edge where `mode_i` is seen low, it was high at the previous edge, and `sel_n_i` is low. A falling `mode_i` while `sel_n_i` is high starts nothing, and `idle_o` stays high.
- R2: Call the first rising edge that sees the falling `mode_i` edge 1. `idle_o` goes low after edge START_DLY+1.
- R3: `idle_o` stays low for exactly CONV_CYC clock cycles and then returns high.
- R4: `sample_i` is captured at edge 1 of R2. Changes on `sample_i` after that edge do not alter the result of that conversion.
- R5: The result register takes the new sample UPDATE_LEAD cycles before `idle_o` rises, so it no longer changes at the cycle `idle_o` rises.
- R6: The enable condition is `mode_i` high, `sel_n_i` low and `idle_o` high. `oe_o` rises exactly ACC_DLY rising edges after the enable condition becomes true and stays true, and never rises otherwise.
- R7: After the enable condition drops, `oe_o` falls exactly REL_DLY rising edges later.
- R8: `dout_o` is all zeros whenever `oe_o` is low.
- R9: While `oe_o` is high, `dout_o` carries the most recent conversion result as a 12-bit two's-complement word, unchanged from the captured sample. For example, 12'h800 is -2048 and 12'h7FF is +2047.
- R10: A start condition of R1 that occurs while a conversion is in progress is ignored. The running conversion keeps its CONV_CYC length and its captured result. `viol_o` goes high and stays high until reset.
- R11: While `rst_n` is low and right after reset, `idle_o` is high, `oe_o` is low, `dout_o` is zero and `viol_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | Read (high) / convert (low) select; a falling edge requests a conversion |
| sel_n_i | input | 1 | Active-low chip select |
| sample_i | input | DW | Test value taken as the analog sample, two's complement |
| idle_o | output | 1 | High when no conversion is running; low during conversion |
| oe_o | output | 1 | Data bus drive enable; low models high impedance |
| dout_o | output | DW | Data bus value, zero while not driven |
| viol_o | output | 1 | Sticky flag: a convert request arrived during a conversion |

## Verification
The bench counts cycles from the falling request edge to the fall of `idle_o`, then the length of the low window, then the delay to bus enable. A design with an off-by-one counter shows a wrong count in one of these. The sample port is changed in the middle of a conversion, and the extreme two's-complement codes are sent, so a design that samples late or reorders bits shows the wrong word on the bus. A request with chip select high and a second request during a conversion are both sent. A design that accepts either one would start a spurious conversion, stretch the low window, overwrite the result, or fail to raise and hold the violation flag. Dropping chip select while the bus is driven checks the release delay.

// File: rtl/adc_emu_pkg.sv
// Package: state encodings shared by the converter interface emulator.
// Assumes: nothing beyond standard enum sizing.
package adc_emu_pkg;

    // Conversion sequencer phases.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LEAD = 2'd1,
        SEQ_CONV = 2'd2
    } seq_state_t;

    // Output bus drive state.
    typedef enum logic {
        BUS_OFF = 1'b0,
        BUS_ON  = 1'b1
    } bus_state_t;

endpackage

// File: rtl/adc_start_det.sv
// Module: detects a convert request, i.e. a falling mode line seen while
// the chip is selected. Assumes mode_i and sel_n_i are synchronous to clk.
module adc_start_det (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic sel_n_i,
    output logic start_o
);

    logic mode_q;

    // Remember last mode level; reset to high so reset release is not an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b1;
        else        mode_q <= mode_i;
    end

    // Request when the mode line was high and is now low with chip selected.
    always_comb begin
        start_o = mode_q && !mode_i && !sel_n_i;
    end

endmodule

// File: rtl/adc_conv_seq.sv
// Module: conversion sequencer. Captures the sample at the request, waits
// START_DLY cycles, holds idle low for CONV_CYC cycles and loads the result
// UPDATE_LEAD cycles before idle returns high. Requests during a conversion
// are dropped and set a sticky violation flag.
// Assumes START_DLY >= 1, CONV_CYC >= 2, 1 <= UPDATE_LEAD < CONV_CYC.
module adc_conv_seq
    import adc_emu_pkg::*;
#(
    parameter int DW          = 12,
    parameter int START_DLY   = 2,
    parameter int CONV_CYC    = 260,
    parameter int UPDATE_LEAD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] sample_i,
    output logic          idle_o,
    output logic [DW-1:0] hold_o,
    output logic [DW-1:0] res_o,
    output logic          viol_o
);

    localparam int CNT_MAX = (CONV_CYC > START_DLY) ? CONV_CYC : START_DLY;
    localparam int CW      = $clog2(CNT_MAX + 1);

    seq_state_t    st_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] hold_q;
    logic [DW-1:0] res_q;
    logic          viol_q;

    // Phase sequencing, sample capture, result load and violation tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SEQ_IDLE;
            cnt_q  <= '0;
            hold_q <= '0;
            res_q  <= '0;
            viol_q <= 1'b0;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        hold_q <= sample_i;
                        cnt_q  <= CW'(START_DLY - 1);
                        st_q   <= SEQ_LEAD;
                    end
                end
                SEQ_LEAD: begin
                    if (start_i) viol_q <= 1'b1;
                    if (cnt_q == '0) begin
                        cnt_q <= CW'(CONV_CYC - 1);
                        st_q  <= SEQ_CONV;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                SEQ_CONV: begin
                    if (start_i) viol_q <= 1'b1;
                    if (cnt_q == CW'(UPDATE_LEAD)) res_q <= hold_q;
                    if (cnt_q == '0) begin
                        st_q <= SEQ_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    // Idle is low only during the conversion window.
    always_comb begin
        idle_o = (st_q != SEQ_CONV);
        hold_o = hold_q;
        res_o  = res_q;
        viol_o = viol_q;
    end

endmodule

// File: rtl/adc_bus_drv.sv
// Module: output bus driver. Turns the bus on ACC_DLY cycles after the
// enable request holds, and off REL_DLY cycles after it drops. The value
// is forced to zero while off. Assumes ACC_DLY >= 1 and REL_DLY >= 1.
module adc_bus_drv
    import adc_emu_pkg::*;
#(
    parameter int DW      = 12,
    parameter int ACC_DLY = 6,
    parameter int REL_DLY = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [DW-1:0] res_i,
    output logic          oe_o,
    output logic [DW-1:0] dout_o
);

    localparam int DMAX = (ACC_DLY > REL_DLY) ? ACC_DLY : REL_DLY;
    localparam int BW   = $clog2(DMAX + 1);

    bus_state_t    st_q;
    logic [BW-1:0] cnt_q;

    // Delay the turn-on and turn-off of the bus by their own counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BUS_OFF;
            cnt_q <= '0;
        end else if (st_q == BUS_OFF) begin
            if (!req_i) begin
                cnt_q <= '0;
            end else if (cnt_q == BW'(ACC_DLY - 1)) begin
                cnt_q <= '0;
                st_q  <= BUS_ON;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            if (req_i) begin
                cnt_q <= '0;
            end else if (cnt_q == BW'(REL_DLY - 1)) begin
                cnt_q <= '0;
                st_q  <= BUS_OFF;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Gate each data bit with the enable; zero models high impedance.
    assign oe_o = (st_q == BUS_ON);
    for (genvar b = 0; b < DW; b++) begin : g_gate
        assign dout_o[b] = res_i[b] & oe_o;
    end

endmodule

// File: rtl/adc_iface_emu.sv
// Module: top of the converter interface emulator. Joins request detection,
// the conversion sequencer and the bus driver. The bus request follows the
// three-way rule: read level, chip selected, not converting.
// Assumes all inputs are synchronous to clk.
module adc_iface_emu #(
    parameter int DW          = 12,
    parameter int START_DLY   = 2,
    parameter int CONV_CYC    = 260,
    parameter int UPDATE_LEAD = 2,
    parameter int ACC_DLY     = 6,
    parameter int REL_DLY     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic          sel_n_i,
    input  logic [DW-1:0] sample_i,
    output logic          idle_o,
    output logic          oe_o,
    output logic [DW-1:0] dout_o,
    output logic          viol_o
);

    logic          start_w;
    logic          bus_req_w;
    logic [DW-1:0] hold_w;
    logic [DW-1:0] res_w;

    adc_start_det u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .sel_n_i (sel_n_i),
        .start_o (start_w)
    );

    adc_conv_seq #(
        .DW          (DW),
        .START_DLY   (START_DLY),
        .CONV_CYC    (CONV_CYC),
        .UPDATE_LEAD (UPDATE_LEAD)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_w),
        .sample_i (sample_i),
        .idle_o   (idle_o),
        .hold_o   (hold_w),
        .res_o    (res_w),
        .viol_o   (viol_o)
    );

    // Bus request: read level, chip selected, and no conversion running.
    always_comb begin
        bus_req_w = mode_i && !sel_n_i && idle_o;
    end

    adc_bus_drv #(
        .DW      (DW),
        .ACC_DLY (ACC_DLY),
        .REL_DLY (REL_DLY)
    ) u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (bus_req_w),
        .res_i  (res_w),
        .oe_o   (oe_o),
        .dout_o (dout_o)
    );

endmodule

// File: rtl/adc_iface_emu_chk.sv
// Module: protocol checker bound to the emulator top. Watches the idle
// window length, bus enable entry, result and hold stability and the sticky
// violation flag. Assumes synchronous active-low reset.
module adc_iface_emu_chk #(
    parameter int DW       = 12,
    parameter int CONV_CYC = 260
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_i,
    input logic          sel_n_i,
    input logic          idle_o,
    input logic          oe_o,
    input logic          viol_o,
    input logic [DW-1:0] hold_q,
    input logic [DW-1:0] res_q
);

    int lo_q;

    // Count consecutive cycles with idle low.
    always_ff @(posedge clk) begin
        if (!rst_n)      lo_q <= 0;
        else if (!idle_o) lo_q <= lo_q + 1;
        else             lo_q <= 0;
    end

    p_low_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_o) |-> (lo_q == CONV_CYC));

    p_oe_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> $past(mode_i && !sel_n_i && idle_o));

    p_res_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_o) |-> $stable(res_q));

    p_hold_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_o |-> $stable(hold_q));

    p_viol_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |=> viol_o);

endmodule

bind adc_iface_emu adc_iface_emu_chk #(
    .DW       (DW),
    .CONV_CYC (CONV_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .sel_n_i (sel_n_i),
    .idle_o  (idle_o),
    .oe_o    (oe_o),
    .viol_o  (viol_o),
    .hold_q  (hold_w),
    .res_q   (res_w)
);

// File: tb/test_adc_iface_emu.sv
`timescale 1ns/1ps
module test_adc_iface_emu;

    localparam int DW  = 12;
    localparam int SD  = 2;
    localparam int CC  = 260;
    localparam int UL  = 2;
    localparam int ACC = 6;
    localparam int REL = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_i = 1'b1;
    logic          sel_n_i = 1'b0;
    logic [DW-1:0] sample_i = '0;
    logic          idle_o;
    logic          oe_o;
    logic [DW-1:0] dout_o;
    logic          viol_o;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_q[$];
    logic          oe_prev = 1'b0;
    logic [DW-1:0] mon_exp;
    int            cyc = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    adc_iface_emu #(
        .DW(DW), .START_DLY(SD), .CONV_CYC(CC), .UPDATE_LEAD(UL),
        .ACC_DLY(ACC), .REL_DLY(REL)
    ) i_adc_iface_emu (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sel_n_i(sel_n_i),
        .sample_i(sample_i), .idle_o(idle_o), .oe_o(oe_o),
        .dout_o(dout_o), .viol_o(viol_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(1'b0, "watchdog", cyc, 100000);
            finish_up();
        end
    end

    // Monitor: on each bus turn-on, pop the expected word and compare (R9).
    always @(negedge clk) begin
        if (!rst_n) begin
            oe_prev = 1'b0;
        end else begin
            if (oe_o && !oe_prev && exp_q.size() > 0) begin
                mon_exp = exp_q.pop_front();
                chk(dout_o == mon_exp, "R9 bus word", int'(dout_o), int'(mon_exp));
            end
            oe_prev = oe_o;
        end
    end

    // Driver: one conversion with full timing checks; pushes expected word.
    task automatic convert(input logic [DW-1:0] v, input logic [DW-1:0] late);
        int n;
        int m;
        int k;
        exp_q.push_back(v);
        @(negedge clk);
        sample_i = v;
        mode_i   = 1'b0;
        n = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            n++;
            if (!idle_o) break;
        end
        chk(n == SD + 1, "R2 start to idle low", n, SD + 1);
        mode_i   = 1'b1;
        sample_i = late;      // R4: must not reach the result
        m = 1;
        for (int i = 0; i < CC + 50; i++) begin
            @(negedge clk);
            if (idle_o) break;
            m++;
        end
        chk(m == CC, "R3 idle low length", m, CC);
        k = 0;
        for (int i = 0; i < 50; i++) begin
            if (oe_o) break;
            chk(dout_o == '0, "R8 bus zero while off", int'(dout_o), 0);
            @(negedge clk);
            k++;
        end
        chk(k == ACC, "R6 access delay", k, ACC);
        @(negedge clk);
    endtask

    initial begin
        int n;
        // R11 reset state
        repeat (3) @(negedge clk);
        chk(idle_o == 1'b1, "R11 idle in reset", int'(idle_o), 1);
        chk(oe_o == 1'b0, "R11 oe in reset", int'(oe_o), 0);
        chk(dout_o == '0, "R11 dout in reset", int'(dout_o), 0);
        chk(viol_o == 1'b0, "R11 viol in reset", int'(viol_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(idle_o == 1'b1 && oe_o == 1'b0, "R11 after reset", int'({idle_o, oe_o}), 2);

        // Main function across patterns, R4/R9 extremes
        convert(12'h123, 12'hABC);
        convert(12'h800, 12'h7FF);
        convert(12'h7FF, 12'h800);
        convert(12'h000, 12'hFFF);
        convert(12'hFFF, 12'h000);
        chk(viol_o == 1'b0, "R10 no violation yet", int'(viol_o), 0);

        // R1: falling mode with chip deselected starts nothing
        @(negedge clk);
        sel_n_i = 1'b1;
        @(negedge clk);
        mode_i = 1'b0;
        sample_i = 12'h555;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!idle_o) n++;
        end
        chk(n == 0, "R1 no start when deselected", n, 0);
        mode_i = 1'b1;
        repeat (2) @(negedge clk);
        sel_n_i = 1'b0;
        repeat (ACC + 2) @(negedge clk);
        chk(oe_o == 1'b1 && dout_o == 12'hFFF, "R9 last result kept", int'(dout_o), 'hFFF);

        // R7: release after deselect
        sel_n_i = 1'b1;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            n++;
            if (!oe_o) break;
        end
        chk(n == REL, "R7 relinquish delay", n, REL);
        chk(dout_o == '0, "R8 zero after release", int'(dout_o), 0);
        @(negedge clk);
        sel_n_i = 1'b0;
        repeat (ACC + 2) @(negedge clk);

        // R10: request during conversion is ignored and flagged
        exp_q.push_back(12'h2A5);
        sample_i = 12'h2A5;
        mode_i = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!idle_o) break;
        end
        n = 1;
        mode_i = 1'b1;
        repeat (3) begin @(negedge clk); n++; end
        sample_i = 12'h111;
        mode_i = 1'b0;
        @(negedge clk); n++;
        mode_i = 1'b1;
        for (int i = 0; i < CC + 50; i++) begin
            @(negedge clk);
            if (idle_o) break;
            n++;
        end
        chk(n == CC, "R10 conversion length kept", n, CC);
        chk(viol_o == 1'b1, "R10 violation flag set", int'(viol_o), 1);
        repeat (ACC + 3) @(negedge clk);
        chk(viol_o == 1'b1, "R10 violation flag sticky", int'(viol_o), 1);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!idle_o) n++;
        end
        chk(n == 0, "R10 no extra conversion", n, 0);

        // R11: reset clears the flag
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(viol_o == 1'b0 && idle_o == 1'b1, "R11 reset clears flag", int'({viol_o, idle_o}), 1);

        chk(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);
        finish_up();
    end

endmodule